// File: doc/BRIEF.md
# Process-Tagged Two-Way Translation Cache with Locking and Bypass Windows

This block keeps recently used virtual-page to physical-frame translations close to the pipeline. Every cached translation carries the 8-bit process identifier that was current when it was loaded. A lookup returns an answer in the same cycle. The answer is either a hit, with the physical address and the page attributes, or a miss. A translation is then loaded through the refill port once the table walk has found it. A refill can mark its entry as locked. A locked entry stays resident through replacement and through a global invalidate, until all locks are released.

The cache is two-way set associative. The low bits of the virtual page number pick a line, and each line has one entry in each way. There are two programmable bypass windows on top of the cache. Each window covers at least 16 MiB of the address space and belongs to one process identifier. An access that falls inside an active window skips the cache and leaves with its physical address equal to its virtual address. It carries the window's own attributes in place of any per-page ones.

Top module: `tagged_tlb`

## Requirements
- R1: After a synchronous active-low reset, no entry is valid, no entry is locked and the process register holds 0. Every lookup outside a window then reports a miss, and `refill_drop` is low.
- R2: A lookup hits only when the entry in the selected line is valid, its stored tag equals the upper page-number bits, and its stored identifier equals the current one. On a hit, `lk_paddr` is the stored frame concatenated with the 12 untranslated offset bits, and `lk_attr` is the stored attribute field. `lk_hit` and `lk_miss` are only ever asserted while `lk_valid` is high, and never together.
- R3: A pulse on `asid_we` loads `asid_wdata` into the process register, which takes effect from the next cycle. A refill is tagged with the register's value at that time. The same page loaded under two identifiers occupies two separate entries, and each identifier sees only its own entry.
- R4: The line index is the low 4 bits of the virtual page number (address bits 15:12). Two different pages that share an index can be resident together, one in each way.
- R5: A refill with no matching entry fills an invalid way of its line before it evicts any valid entry. Way 0 is preferred when both ways are invalid.
- R6: Each line records which way was used most recently, through a lookup hit or a refill. If both ways are valid and unlocked, a refill replaces the other way.
- R7: A locked entry is never replaced. If only one way is unlocked, that way is used. If both ways are valid and locked, the refill is discarded without changing anything, and `refill_drop` is high for the one cycle after it.
- R8: A refill whose page and current identifier already match a valid entry overwrites that entry in place, so no duplicate is created.
- R9: A pulse on `inval_all` clears every unlocked entry and leaves locked entries valid. A refill in the same cycle is ignored.
- R10: A pulse on `unlock_all` releases every lock. The released entries stay valid, but later replacements and invalidates can now remove them.
- R11: A window matches when it is enabled, its identifier equals the current one, and address bits 31:24 equal its base on every bit where the mask is 0. On a match, `lk_bypass` and `lk_hit` are high, `lk_paddr` equals `lk_vaddr`, and `lk_attr` is the window's attribute. The cache contents have no effect. Window 0 takes priority over window 1.
- R12: A window belonging to another identifier does not apply. Such an address goes through the cache as a normal lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| asid_we | input | 1 | Load the process register |
| asid_wdata | input | 8 | New process identifier |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Translation found (cache or window) |
| lk_miss | output | 1 | No translation found |
| lk_bypass | output | 1 | Address fell inside a bypass window |
| lk_paddr | output | 32 | Physical address |
| lk_attr | output | 4 | Attributes of the page or window |
| refill_en | input | 1 | Load one translation |
| refill_vpn | input | 20 | Virtual page number to load |
| refill_pfn | input | 20 | Physical frame number to load |
| refill_attr | input | 4 | Attributes to load |
| refill_lock | input | 1 | Lock the loaded entry |
| refill_drop | output | 1 | Previous-cycle refill was discarded, both ways locked |
| inval_all | input | 1 | Invalidate every unlocked entry |
| unlock_all | input | 1 | Release every lock |
| win_en | input | 2 | Enable per window |
| win_base | input | 16 | Per-window base of address bits 31:24 |
| win_mask | input | 16 | Per-window don't-care bits for the base compare |
| win_asid | input | 16 | Per-window process identifier |
| win_attr | input | 8 | Per-window attribute field |

## Verification
The bench fills one line and drives its recently-used bit in both directions, then loads pages that the following lookups show were placed correctly. If the design evicted the recently used way, or evicted on a fixed rotation, a page that should have survived would then miss. It locks one way and then both ways, and invalidates with locks held. A design that let a locked entry go, or that failed to flag the discarded refill, would lose a locked page or leave `refill_drop` low. It also reloads a page that is already resident and then looks up its neighbour. A design that made a duplicate would push the neighbour out. Finally it runs lookups against overlapping windows and windows belonging to another identifier. Wrong priority or a missing identifier check would show up as the wrong attribute or as a bypass where a miss was expected.

// File: rtl/tagged_tlb_pkg.sv
// Package: shared defaults and the victim-choice outcome type for the
// process-tagged translation cache. Assumes exactly two ways.
package tagged_tlb_pkg;
    localparam int unsigned DEF_VA_W   = 32;
    localparam int unsigned DEF_PG_W   = 12;
    localparam int unsigned DEF_PFN_W  = 20;
    localparam int unsigned DEF_SETS   = 16;
    localparam int unsigned DEF_ASID_W = 8;
    localparam int unsigned DEF_ATTR_W = 4;
    localparam int unsigned DEF_WIN_N  = 2;
    localparam int unsigned DEF_WIN_W  = 8;

    // How a refill picks its way.
    typedef enum logic [1:0] {
        VIC_MATCH   = 2'd0,  // same page and identifier already resident
        VIC_EMPTY   = 2'd1,  // an invalid way is available
        VIC_REPLACE = 2'd2,  // evict an unlocked valid way
        VIC_BLOCKED = 2'd3   // both ways locked, refill discarded
    } vic_kind_t;
endpackage

// File: rtl/tagged_tlb_way.sv
// Module: one way of the cache. Holds valid, lock, identifier, tag, frame
// and attribute per line. It compares one line for the lookup port and one
// line for the refill port. Assumes wr_en is already gated against a
// same-cycle global invalidate by the parent.
module tagged_tlb_way #(
    parameter int unsigned SETS   = 16,
    parameter int unsigned TAG_W  = 16,
    parameter int unsigned PFN_W  = 20,
    parameter int unsigned ASID_W = 8,
    parameter int unsigned ATTR_W = 4,
    localparam int unsigned IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              hit_o,
    output logic [PFN_W-1:0]  pfn_o,
    output logic [ATTR_W-1:0] attr_o,
    input  logic [IDX_W-1:0]  rf_idx,
    input  logic [TAG_W-1:0]  rf_tag,
    output logic              rf_match_o,
    output logic              rf_vld_o,
    output logic              rf_lck_o,
    input  logic              wr_en,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic [ATTR_W-1:0] wr_attr,
    input  logic              wr_lock,
    input  logic              inval_all,
    input  logic              unlock_all
);
    logic              vld_q  [SETS];
    logic              lck_q  [SETS];
    logic [ASID_W-1:0] asid_q [SETS];
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [PFN_W-1:0]  pfn_q  [SETS];
    logic [ATTR_W-1:0] attr_q [SETS];

    // Lookup compare: valid, tag and identifier must all agree.
    always_comb begin
        hit_o  = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag) && (asid_q[lk_idx] == cur_asid);
        pfn_o  = pfn_q[lk_idx];
        attr_o = attr_q[lk_idx];
    end

    // Refill-side view of the addressed line for the victim chooser.
    always_comb begin
        rf_vld_o   = vld_q[rf_idx];
        rf_lck_o   = lck_q[rf_idx];
        rf_match_o = vld_q[rf_idx] && (tag_q[rf_idx] == rf_tag) && (asid_q[rf_idx] == cur_asid);
    end

    // Valid and lock state: reset, invalidate sparing locks, fill, unlock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) begin
                vld_q[i] <= 1'b0;
                lck_q[i] <= 1'b0;
            end
        end else begin
            if (inval_all) begin
                for (int i = 0; i < SETS; i++) begin
                    if (!lck_q[i]) vld_q[i] <= 1'b0;
                end
            end else if (wr_en) begin
                vld_q[rf_idx] <= 1'b1;
                lck_q[rf_idx] <= wr_lock;
            end
            if (unlock_all) begin
                for (int i = 0; i < SETS; i++) lck_q[i] <= 1'b0;
            end
        end
    end

    // Payload fields: written on a committed fill, never reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            asid_q[rf_idx] <= cur_asid;
            tag_q[rf_idx]  <= rf_tag;
            pfn_q[rf_idx]  <= wr_pfn;
            attr_q[rf_idx] <= wr_attr;
        end
    end

    // R9: a locked valid entry survives a global invalidate.
    a_r9_locked_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (inval_all && rf_vld_o && rf_lck_o) |=> vld_q[$past(rf_idx)]);

    // R5: a committed fill leaves its line valid.
    a_r5_fill_valid: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> vld_q[$past(rf_idx)]);
endmodule

// File: rtl/tagged_tlb_victim.sv
// Module: chooses the way a refill writes. The order is a matching entry,
// then an invalid way (way 0 first), then the unlocked way other than the
// most recently used one, then any unlocked way. If none is left the
// refill is blocked. Purely combinational; assumes two ways.
module tagged_tlb_victim
    import tagged_tlb_pkg::*;
(
    input  logic [1:0] match_i,
    input  logic [1:0] vld_i,
    input  logic [1:0] lck_i,
    input  logic       mru_i,
    output logic       way_o,
    output vic_kind_t  kind_o
);
    logic pref;

    // Priority decision for the refill target.
    always_comb begin
        pref   = ~mru_i;
        way_o  = 1'b0;
        kind_o = VIC_MATCH;
        if (match_i[0]) begin
            way_o = 1'b0;
        end else if (match_i[1]) begin
            way_o = 1'b1;
        end else if (!vld_i[0]) begin
            way_o  = 1'b0;
            kind_o = VIC_EMPTY;
        end else if (!vld_i[1]) begin
            way_o  = 1'b1;
            kind_o = VIC_EMPTY;
        end else if (!lck_i[pref]) begin
            way_o  = pref;
            kind_o = VIC_REPLACE;
        end else if (!lck_i[~pref]) begin
            way_o  = ~pref;
            kind_o = VIC_REPLACE;
        end else begin
            kind_o = VIC_BLOCKED;
        end
    end
endmodule

// File: rtl/tagged_tlb_window.sv
// Module: one bypass window. Compares the top address bits against a base
// under a don't-care mask, qualified by enable and the owning identifier.
module tagged_tlb_window #(
    parameter int unsigned WIN_W  = 8,
    parameter int unsigned ASID_W = 8
) (
    input  logic [WIN_W-1:0]  va_top,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic              en,
    input  logic [WIN_W-1:0]  base,
    input  logic [WIN_W-1:0]  mask,
    input  logic [ASID_W-1:0] owner,
    output logic              hit
);
    // Region membership test.
    always_comb begin
        hit = en && (owner == cur_asid) && (((va_top ^ base) & ~mask) == '0);
    end
endmodule

// File: rtl/tagged_tlb.sv
// Module: top of the process-tagged translation cache. Single-cycle lookup
// that returns window bypass or cache hit, or a miss. Refill port with
// locking and one recently-used bit per line. Global invalidate spares
// locked entries. Assumes the address and frame widths add up as stated by
// the parameters, and that windows are configured statically.
module tagged_tlb
    import tagged_tlb_pkg::*;
#(
    parameter int unsigned VA_W   = DEF_VA_W,
    parameter int unsigned PG_W   = DEF_PG_W,
    parameter int unsigned PFN_W  = DEF_PFN_W,
    parameter int unsigned SETS   = DEF_SETS,
    parameter int unsigned ASID_W = DEF_ASID_W,
    parameter int unsigned ATTR_W = DEF_ATTR_W,
    parameter int unsigned WIN_N  = DEF_WIN_N,
    parameter int unsigned WIN_W  = DEF_WIN_W,
    localparam int unsigned VPN_W = VA_W - PG_W,
    localparam int unsigned PA_W  = PFN_W + PG_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    asid_we,
    input  logic [ASID_W-1:0]       asid_wdata,
    input  logic                    lk_valid,
    input  logic [VA_W-1:0]         lk_vaddr,
    output logic                    lk_hit,
    output logic                    lk_miss,
    output logic                    lk_bypass,
    output logic [PA_W-1:0]         lk_paddr,
    output logic [ATTR_W-1:0]       lk_attr,
    input  logic                    refill_en,
    input  logic [VPN_W-1:0]        refill_vpn,
    input  logic [PFN_W-1:0]        refill_pfn,
    input  logic [ATTR_W-1:0]       refill_attr,
    input  logic                    refill_lock,
    output logic                    refill_drop,
    input  logic                    inval_all,
    input  logic                    unlock_all,
    input  logic [WIN_N-1:0]        win_en,
    input  logic [WIN_N*WIN_W-1:0]  win_base,
    input  logic [WIN_N*WIN_W-1:0]  win_mask,
    input  logic [WIN_N*ASID_W-1:0] win_asid,
    input  logic [WIN_N*ATTR_W-1:0] win_attr
);
    localparam int unsigned IDX_W = $clog2(SETS);
    localparam int unsigned TAG_W = VPN_W - IDX_W;
    localparam int unsigned WAYS  = 2;

    logic [ASID_W-1:0] asid_q;
    logic [SETS-1:0]   mru_q;
    logic              drop_q;

    logic [VPN_W-1:0]  lk_vpn;
    logic [IDX_W-1:0]  lk_idx, rf_idx;
    logic [TAG_W-1:0]  lk_tag, rf_tag;

    logic [WAYS-1:0]   way_hit, rf_match, rf_vld, rf_lck, way_wr;
    logic [PFN_W-1:0]  way_pfn  [WAYS];
    logic [ATTR_W-1:0] way_attr [WAYS];

    logic [WIN_N-1:0]  win_hit;
    logic              win_any;
    logic [ATTR_W-1:0] win_attr_sel;

    logic              vic_way;
    vic_kind_t         vic_kind;
    logic              rf_go, rf_commit, rf_block;
    logic              tlb_hit, hit_way;

    // Split the addresses into line index and tag.
    always_comb begin
        lk_vpn = lk_vaddr[VA_W-1:PG_W];
        lk_idx = lk_vpn[IDX_W-1:0];
        lk_tag = lk_vpn[VPN_W-1:IDX_W];
        rf_idx = refill_vpn[IDX_W-1:0];
        rf_tag = refill_vpn[VPN_W-1:IDX_W];
    end

    // Process identifier register, loaded by software.
    always_ff @(posedge clk) begin
        if (!rst_n)       asid_q <= '0;
        else if (asid_we) asid_q <= asid_wdata;
    end

    // Storage ways.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        tagged_tlb_way #(
            .SETS(SETS), .TAG_W(TAG_W), .PFN_W(PFN_W),
            .ASID_W(ASID_W), .ATTR_W(ATTR_W)
        ) u_way (
            .clk(clk), .rst_n(rst_n), .cur_asid(asid_q),
            .lk_idx(lk_idx), .lk_tag(lk_tag),
            .hit_o(way_hit[w]), .pfn_o(way_pfn[w]), .attr_o(way_attr[w]),
            .rf_idx(rf_idx), .rf_tag(rf_tag),
            .rf_match_o(rf_match[w]), .rf_vld_o(rf_vld[w]), .rf_lck_o(rf_lck[w]),
            .wr_en(way_wr[w]), .wr_pfn(refill_pfn), .wr_attr(refill_attr),
            .wr_lock(refill_lock), .inval_all(inval_all), .unlock_all(unlock_all)
        );
    end

    // Bypass windows.
    for (genvar k = 0; k < WIN_N; k++) begin : g_win
        tagged_tlb_window #(.WIN_W(WIN_W), .ASID_W(ASID_W)) u_win (
            .va_top(lk_vaddr[VA_W-1 -: WIN_W]), .cur_asid(asid_q),
            .en(win_en[k]), .base(win_base[k*WIN_W +: WIN_W]),
            .mask(win_mask[k*WIN_W +: WIN_W]), .owner(win_asid[k*ASID_W +: ASID_W]),
            .hit(win_hit[k])
        );
    end

    // Window priority: the lowest index wins.
    always_comb begin
        win_any      = 1'b0;
        win_attr_sel = '0;
        for (int k = WIN_N - 1; k >= 0; k--) begin
            if (win_hit[k]) begin
                win_any      = 1'b1;
                win_attr_sel = win_attr[k*ATTR_W +: ATTR_W];
            end
        end
    end

    // Lookup result: a window overrides the cache.
    always_comb begin
        tlb_hit   = |way_hit;
        hit_way   = ~way_hit[0];
        lk_bypass = lk_valid && win_any;
        lk_hit    = lk_valid && (win_any || tlb_hit);
        lk_miss   = lk_valid && !win_any && !tlb_hit;
        if (win_any) begin
            lk_paddr = PA_W'(lk_vaddr);
            lk_attr  = win_attr_sel;
        end else begin
            lk_paddr = {way_pfn[hit_way], lk_vaddr[PG_W-1:0]};
            lk_attr  = way_attr[hit_way];
        end
    end

    // Victim selection for the refill line.
    tagged_tlb_victim u_victim (
        .match_i(rf_match), .vld_i(rf_vld), .lck_i(rf_lck),
        .mru_i(mru_q[rf_idx]), .way_o(vic_way), .kind_o(vic_kind)
    );

    // Refill commit gating: invalidate wins, a blocked line drops.
    always_comb begin
        rf_go     = refill_en && !inval_all;
        rf_commit = rf_go && (vic_kind != VIC_BLOCKED);
        rf_block  = rf_go && (vic_kind == VIC_BLOCKED);
        for (int w = 0; w < WAYS; w++) way_wr[w] = rf_commit && (vic_way == w[0]);
    end

    // Recently-used bit per line: lookup hits, then refills take precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mru_q <= '0;
        end else begin
            if (lk_valid && !win_any && tlb_hit) mru_q[lk_idx] <= hit_way;
            if (rf_commit)                       mru_q[rf_idx] <= vic_way;
        end
    end

    // One-cycle drop flag for a refill that found both ways locked.
    always_ff @(posedge clk) begin
        if (!rst_n) drop_q <= 1'b0;
        else        drop_q <= rf_block;
    end
    assign refill_drop = drop_q;

    // R8: the ways never both hold the looked-up page.
    a_r8_single_way_hit: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> $onehot0(way_hit));

    // R7: a committed replacement never targets a locked way.
    a_r7_no_locked_victim: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_commit && rf_vld == 2'b11 && rf_match == 2'b00) |-> !rf_lck[vic_way]);

    // R7: a full locked line raises the drop flag the next cycle.
    a_r7_drop_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_go && rf_vld == 2'b11 && rf_lck == 2'b11 && rf_match == 2'b00) |=> refill_drop);

    // R6: with both ways free to go, the recently used one is kept.
    a_r6_not_mru: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_go && rf_match == 2'b00 && rf_vld == 2'b11 && rf_lck == 2'b00)
        |-> (vic_way != mru_q[rf_idx]));

    // R11: a bypass returns the virtual address unchanged.
    a_r11_identity: assert property (@(posedge clk) disable iff (!rst_n)
        lk_bypass |-> (lk_hit && !lk_miss && lk_paddr == PA_W'(lk_vaddr)));

    // R2: hit and miss are exclusive and need a request.
    a_r2_hit_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit || lk_miss) |-> (lk_valid && !(lk_hit && lk_miss)));
endmodule

// File: tb/tagged_tlb_bench.sv
`timescale 1ns/1ps
// Bench: a vector table of lookups after a fixed fill, then directed
// sequences for replacement order, locking, invalidate and unlock.
module tagged_tlb_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        asid_we = 1'b0;
    logic [7:0]  asid_wdata = '0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_hit, lk_miss, lk_bypass, refill_drop;
    logic [31:0] lk_paddr;
    logic [3:0]  lk_attr;
    logic        refill_en = 1'b0;
    logic [19:0] refill_vpn = '0;
    logic [19:0] refill_pfn = '0;
    logic [3:0]  refill_attr = '0;
    logic        refill_lock = 1'b0;
    logic        inval_all = 1'b0;
    logic        unlock_all = 1'b0;
    // Window 0: base 0x90, exact, owner 5, attr 0xA.
    // Window 1: base 0x80, mask 0x7F, owner 5, attr 0x6.
    logic [1:0]  win_en   = 2'b11;
    logic [15:0] win_base = {8'h80, 8'h90};
    logic [15:0] win_mask = {8'h7F, 8'h00};
    logic [15:0] win_asid = {8'h05, 8'h05};
    logic [7:0]  win_attr = {4'h6, 4'hA};

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Captured lookup outputs.
    logic        o_hit, o_miss, o_byp;
    logic [31:0] o_pa;
    logic [3:0]  o_attr;

    tagged_tlb u_tagged_tlb (
        .clk(clk), .rst_n(rst_n), .asid_we(asid_we), .asid_wdata(asid_wdata),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_miss(lk_miss),
        .lk_bypass(lk_bypass), .lk_paddr(lk_paddr), .lk_attr(lk_attr),
        .refill_en(refill_en), .refill_vpn(refill_vpn), .refill_pfn(refill_pfn),
        .refill_attr(refill_attr), .refill_lock(refill_lock), .refill_drop(refill_drop),
        .inval_all(inval_all), .unlock_all(unlock_all), .win_en(win_en),
        .win_base(win_base), .win_mask(win_mask), .win_asid(win_asid), .win_attr(win_attr)
    );

    always #10 clk = ~clk;

    // Row: asid[77:70] va[69:38] hit[37] byp[36] pa[35:4] attr[3:0]
    localparam logic [77:0] VEC [9] = '{
        {8'h05, 32'h0001_0123, 1'b1, 1'b0, 32'hABCD_E123, 4'h3},
        {8'h05, 32'h0002_0FFF, 1'b1, 1'b0, 32'h1234_5FFF, 4'h5},
        {8'h05, 32'h0003_3000, 1'b1, 1'b0, 32'h5555_5000, 4'h1},
        {8'h06, 32'h0001_0123, 1'b0, 1'b0, 32'h0,         4'h0},
        {8'h05, 32'h0003_0000, 1'b0, 1'b0, 32'h0,         4'h0},
        {8'h05, 32'h9012_3456, 1'b1, 1'b1, 32'h9012_3456, 4'hA},
        {8'h05, 32'hA000_0010, 1'b1, 1'b1, 32'hA000_0010, 4'h6},
        {8'h06, 32'h9000_0000, 1'b0, 1'b0, 32'h0,         4'h0},
        {8'h05, 32'h7FFF_F000, 1'b0, 1'b0, 32'h0,         4'h0}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_asid(input logic [7:0] a);
        asid_we = 1'b1; asid_wdata = a;
        tick();
        asid_we = 1'b0;
    endtask

    task automatic look(input logic [31:0] va);
        lk_valid = 1'b1; lk_vaddr = va;
        #1;
        o_hit = lk_hit; o_miss = lk_miss; o_byp = lk_bypass; o_pa = lk_paddr; o_attr = lk_attr;
        tick();
        lk_valid = 1'b0;
    endtask

    task automatic refill(input logic [19:0] vpn, input logic [19:0] pfn,
                          input logic [3:0] attr, input bit lock);
        refill_en = 1'b1; refill_vpn = vpn; refill_pfn = pfn;
        refill_attr = attr; refill_lock = lock;
        tick();
        refill_en = 1'b0; refill_lock = 1'b0;
    endtask

    task automatic pulse_inval();
        inval_all = 1'b1; tick(); inval_all = 1'b0;
    endtask

    task automatic pulse_unlock();
        unlock_all = 1'b1; tick(); unlock_all = 1'b0;
    endtask

    task automatic exp_hit(input logic [19:0] vpn, input logic [19:0] pfn, input string req);
        look({vpn, 12'h2A4});
        chk(o_hit && !o_miss && !o_byp, req, {o_hit, o_miss, o_byp}, 3'b100);
        chk(o_pa == {pfn, 12'h2A4}, req, o_pa, {pfn, 12'h2A4});
    endtask

    task automatic exp_miss(input logic [19:0] vpn, input string req);
        look({vpn, 12'h2A4});
        chk(!o_hit && o_miss && !o_byp, req, {o_hit, o_miss, o_byp}, 3'b010);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset, identifier 0, no drop.
        chk(refill_drop == 1'b0, "R1 drop low", refill_drop, 0);
        exp_miss(20'h00001, "R1 empty");
        look(32'h9000_0000);
        chk(o_miss && !o_byp, "R1/R12 window owner 5 not active at id 0", {o_miss, o_byp}, 2'b10);

        // Fill: set 0 gets two pages, set 3 one page, all under id 5.
        set_asid(8'h05);
        refill(20'h00010, 20'hABCDE, 4'h3, 1'b0);
        refill(20'h00020, 20'h12345, 4'h5, 1'b0);   // R5/R4 second way of set 0
        refill(20'h00033, 20'h55555, 4'h1, 1'b0);

        // Vector table: R2, R3, R4, R11, R12 lookups.
        for (int i = 0; i < 9; i++) begin
            set_asid(VEC[i][77:70]);
            look(VEC[i][69:38]);
            chk(o_hit == VEC[i][37] && o_miss == !VEC[i][37] && o_byp == VEC[i][36],
                "R2/R11/R12 flags", {o_hit, o_miss, o_byp}, {VEC[i][37], !VEC[i][37], VEC[i][36]});
            if (VEC[i][37])
                chk(o_pa == VEC[i][35:4] && o_attr == VEC[i][3:0], "R2/R11 addr+attr",
                    {o_pa, o_attr}, {VEC[i][35:4], VEC[i][3:0]});
        end
        set_asid(8'h05);

        // R6: recently used way 1 kept, then way 0 kept.
        refill(20'h00040, 20'h44444, 4'h2, 1'b0);
        exp_miss(20'h00010, "R6 evict way0");
        exp_hit(20'h00020, 20'h12345, "R6 keep mru");
        exp_hit(20'h00040, 20'h44444, "R6 new");
        refill(20'h00050, 20'h50505, 4'h2, 1'b0);
        exp_miss(20'h00020, "R6 evict way1");
        exp_hit(20'h00040, 20'h44444, "R6 keep mru2");
        exp_hit(20'h00050, 20'h50505, "R6 new2");

        // R8: reload a resident page in place.
        refill(20'h00040, 20'h0F0F0, 4'h2, 1'b0);
        exp_hit(20'h00040, 20'h0F0F0, "R8 updated");
        exp_hit(20'h00050, 20'h50505, "R8 neighbour kept");

        // R7: locking.
        refill(20'h00060, 20'h66666, 4'h0, 1'b1);
        refill(20'h00070, 20'h77777, 4'h0, 1'b0);
        refill(20'h00080, 20'h88888, 4'h0, 1'b0);
        exp_hit(20'h00060, 20'h66666, "R7 locked kept");
        exp_miss(20'h00070, "R7 unlocked way used");
        exp_hit(20'h00080, 20'h88888, "R7 new");
        refill(20'h00090, 20'h99990, 4'h0, 1'b1);
        chk(refill_drop == 1'b0, "R7 no drop when a way is free", refill_drop, 0);
        refill(20'h000A0, 20'hAAAAA, 4'h0, 1'b0);
        chk(refill_drop == 1'b1, "R7 drop flag", refill_drop, 1);
        tick();
        chk(refill_drop == 1'b0, "R7 drop one cycle", refill_drop, 0);
        exp_miss(20'h000A0, "R7 dropped refill absent");
        exp_hit(20'h00060, 20'h66666, "R7 lock0 kept");
        exp_hit(20'h00090, 20'h99990, "R7 lock1 kept");

        // R9: invalidate spares locked entries.
        pulse_inval();
        exp_miss(20'h00033, "R9 unlocked cleared");
        exp_hit(20'h00060, 20'h66666, "R9 locked0 kept");
        exp_hit(20'h00090, 20'h99990, "R9 locked1 kept");

        // R3: same page under two identifiers.
        set_asid(8'h09);
        refill(20'h00033, 20'h99999, 4'h0, 1'b0);
        set_asid(8'h05);
        refill(20'h00033, 20'h55AA5, 4'h0, 1'b0);
        exp_hit(20'h00033, 20'h55AA5, "R3 id5 entry");
        set_asid(8'h09);
        exp_hit(20'h00033, 20'h99999, "R3 id9 entry");
        set_asid(8'h05);

        // R10: unlock makes entries replaceable and invalidatable.
        exp_hit(20'h00060, 20'h66666, "R10 pre");
        exp_hit(20'h00090, 20'h99990, "R10 pre");
        pulse_unlock();
        exp_hit(20'h00090, 20'h99990, "R10 still valid");
        refill(20'h000A0, 20'hAAAAA, 4'h0, 1'b0);
        chk(refill_drop == 1'b0, "R10 refill accepted", refill_drop, 0);
        exp_miss(20'h00060, "R10 unlocked evicted");
        exp_hit(20'h000A0, 20'hAAAAA, "R10 new");
        pulse_inval();
        exp_miss(20'h00090, "R10 invalidated after unlock");
        exp_miss(20'h000A0, "R9 invalidated");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule